// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between the command scheduler of a memory controller and the clock-enable pin of an SDRAM device. It decides when the device may drop into power-down or deep power-down. It watches the scheduler's activity and counts idle cycles. When the programmed idle window has elapsed, it takes clock-enable low while the command bus carries only NOP.

A new request during power-down raises clock-enable at once. The sequencer then withholds its grant for a short fixed wake-up delay. In deep power-down the sequencer issues a single entry strobe and freezes. It reports the frozen condition until software clears the low-power command and an external initialization sequence signals completion.

Top module: `sdram_lp_seq`

## Requirements
- R1: While rst_ni is low, and right after it rises, cke_o=1, ready_o=1, frozen_o=0 and dpd_cmd_o=0.
- R2: When lp_cmd_i is 2'b00 or 2'b01, no low-power state is entered. If cke_o is high, it stays high on the next cycle.
- R3: With lp_cmd_i=2'b10 and timeout_i at 2'b00 or the reserved 2'b11, power-down is entered after the first idle clock edge. An idle edge is one where dev_sel_i, req_i and burst_busy_i are all low. cke_o is low and ready_o is low from that edge on.
- R4: With lp_cmd_i=2'b10 and timeout_i=2'b01, cke_o stays high through 64 consecutive idle edges after the last active one. It falls after the 65th.
- R5: With lp_cmd_i=2'b10 and timeout_i=2'b10, cke_o stays high through 128 consecutive idle edges. It falls after the 129th.
- R6: Any edge with dev_sel_i high restarts the idle count, which cancels a pending entry.
- R7: No low-power entry happens on an edge where burst_busy_i, req_i or dev_sel_i is high.
- R8: In power-down, either req_i high or lp_cmd_i leaving 2'b10 raises cke_o after that edge. ready_o then stays low for EXIT_CYC (2) cycles and rises on the following edge.
- R9: With lp_cmd_i=2'b11 and an idle edge, the block enters deep power-down regardless of timeout_i. dpd_cmd_o is high for exactly one cycle, in the same cycle that cke_o goes low, and frozen_o rises.
- R10: While frozen_o is high, ready_o is low. In deep power-down, req_i and init_done_i have no effect, and cke_o stays low while lp_cmd_i is not 2'b00.
- R11: When lp_cmd_i returns to 2'b00 in deep power-down, cke_o rises while frozen_o stays high and ready_o stays low. The first edge with init_done_i high then restores ready_o=1 and frozen_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_cmd_i | input | 2 | Low-power command: 00/01 off, 10 power-down, 11 deep power-down |
| timeout_i | input | 2 | Idle window: 00/11 immediate, 01 short, 10 long |
| dev_sel_i | input | 1 | Device selected / access active this cycle |
| req_i | input | 1 | Access request from the scheduler |
| burst_busy_i | input | 1 | Burst or read still in flight |
| init_done_i | input | 1 | External initialization finished (pulse) |
| cke_o | output | 1 | SDRAM clock enable |
| dpd_cmd_o | output | 1 | One-cycle deep power-down command strobe |
| ready_o | output | 1 | Grant to the scheduler; access may be issued |
| frozen_o | output | 1 | Controller frozen by deep power-down |

## Verification
The bench builds the block with its default parameters: idle windows of 64 and 128 cycles and a two-cycle wake delay. Because these are the real values, the exact cycle on which clock-enable falls is checked at both window boundaries, along with the restart of the count by a mid-window access. The same values make the exact length of the withheld grant on wake-up observable.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_PD,
    ST_EXIT,
    ST_DPD,
    ST_INIT
  } lp_state_e;

  localparam logic [1:0] LP_OFF = 2'b00;
  localparam logic [1:0] LP_PD  = 2'b10;
  localparam logic [1:0] LP_DPD = 2'b11;

  localparam logic [1:0] TO_SHORT = 2'b01;
  localparam logic [1:0] TO_LONG  = 2'b10;
endpackage

// File: rtl/sdram_lp_idle_timer.sv
module sdram_lp_idle_timer #(
  parameter int SHORT_IDLE = 64,
  parameter int LONG_IDLE  = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] timeout_i,
  output logic       expired_o
);
  import sdram_lp_pkg::*;

  localparam int CNT_W = $clog2(LONG_IDLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_IDLE);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // reserved code falls back to immediate entry
  always_comb begin
    case (timeout_i)
      TO_SHORT: thr = CNT_W'(SHORT_IDLE);
      TO_LONG:  thr = CNT_W'(LONG_IDLE);
      default:  thr = '0;
    endcase
  end

  assign expired_o = (cnt_q >= thr);
endmodule

// File: rtl/sdram_lp_exit_timer.sv
module sdram_lp_exit_timer #(
  parameter int EXIT_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int W = (EXIT_CYC < 2) ? 1 : $clog2(EXIT_CYC);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (!run_i) q <= '0;
    else if (!done_o) q <= q + 1'b1;
  end

  assign done_o = (q == W'(EXIT_CYC - 1));
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq #(
  parameter int SHORT_IDLE = 64,
  parameter int LONG_IDLE  = 128,
  parameter int EXIT_CYC   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] lp_cmd_i,
  input  logic [1:0] timeout_i,
  input  logic       dev_sel_i,
  input  logic       req_i,
  input  logic       burst_busy_i,
  input  logic       init_done_i,
  output logic       cke_o,
  output logic       dpd_cmd_o,
  output logic       ready_o,
  output logic       frozen_o
);
  import sdram_lp_pkg::*;

  lp_state_e state_q, state_d;
  logic      dpd_q, dpd_d;
  logic      idle, expired, exit_done;

  assign idle = !dev_sel_i && !req_i && !burst_busy_i;

  sdram_lp_idle_timer #(
    .SHORT_IDLE(SHORT_IDLE),
    .LONG_IDLE (LONG_IDLE)
  ) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!(state_q == ST_RUN && idle)),
    .timeout_i(timeout_i),
    .expired_o(expired)
  );

  sdram_lp_exit_timer #(
    .EXIT_CYC(EXIT_CYC)
  ) u_exit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_EXIT),
    .done_o(exit_done)
  );

  always_comb begin
    state_d = state_q;
    dpd_d   = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (lp_cmd_i == LP_DPD && idle) begin
          state_d = ST_DPD;
          dpd_d   = 1'b1;
        end else if (lp_cmd_i == LP_PD && idle && expired) begin
          state_d = ST_PD;
        end
      end
      ST_PD:   if (req_i || lp_cmd_i != LP_PD) state_d = ST_EXIT;
      ST_EXIT: if (exit_done) state_d = ST_RUN;
      ST_DPD:  if (lp_cmd_i == LP_OFF) state_d = ST_INIT;
      ST_INIT: if (init_done_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      dpd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dpd_q   <= dpd_d;
    end
  end

  assign cke_o     = !(state_q == ST_PD || state_q == ST_DPD);
  assign dpd_cmd_o = dpd_q;
  assign ready_o   = (state_q == ST_RUN);
  assign frozen_o  = (state_q == ST_DPD || state_q == ST_INIT);
endmodule

// File: rtl/sdram_lp_seq_chk.sv
module sdram_lp_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] lp_cmd_i,
  input logic       dev_sel_i,
  input logic       req_i,
  input logic       burst_busy_i,
  input logic       cke_o,
  input logic       dpd_cmd_o,
  input logic       ready_o,
  input logic       frozen_o
);
  AST_DPD_CKE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpd_cmd_o |-> !cke_o && frozen_o); // R9
  AST_DPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpd_cmd_o |=> !dpd_cmd_o); // R9
  AST_FROZEN_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> !ready_o); // R10
  AST_ENTRY_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> $past(!burst_busy_i && !dev_sel_i && !req_i)); // R7
  AST_WAKE_HOLDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> !ready_o); // R8
  AST_LP_OFF_KEEPS_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_cmd_i[1] && cke_o) |=> cke_o); // R2
endmodule

bind sdram_lp_seq sdram_lp_seq_chk u_chk (.*);

// File: tb/sdram_lp_seq_test.sv
module sdram_lp_seq_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] lp_cmd, tmo;
  logic       sel, req, busy, init;
  logic       cke, dpd, rdy, frz;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  sdram_lp_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .lp_cmd_i(lp_cmd), .timeout_i(tmo),
    .dev_sel_i(sel), .req_i(req), .burst_busy_i(busy), .init_done_i(init),
    .cke_o(cke), .dpd_cmd_o(dpd), .ready_o(rdy), .frozen_o(frz)
  );

  // {lp[1:0], tmo[1:0], sel, req, busy, init, cke, rdy, frz, dpd}
  localparam int NV = 23;
  localparam logic [11:0] VEC [NV] = '{
    12'b00_00_1000_1100, // R1 R2 active, stays up
    12'b00_00_0000_1100, // R2 off
    12'b01_00_0000_1100, // R2 code 01
    12'b10_00_0010_1100, // R7 busy
    12'b10_00_0100_1100, // R7 request
    12'b10_00_0000_0000, // R3 immediate entry
    12'b10_00_0000_0000, // R3 hold
    12'b10_00_0100_1000, // R8 wake
    12'b10_00_0100_1000, // R8 exit delay
    12'b10_00_0100_1100, // R8 granted
    12'b10_11_1000_1100, // R3 active
    12'b10_11_0000_0000, // R3 reserved code
    12'b00_11_0000_1000, // R8 command cleared
    12'b00_11_0000_1000, // R8
    12'b00_11_0000_1100, // R8
    12'b11_00_0010_1100, // R7 busy blocks deep entry
    12'b11_01_0000_0011, // R9 deep entry
    12'b11_01_0100_0010, // R10 request ignored
    12'b11_01_0001_0010, // R10 init ignored
    12'b00_00_0000_1010, // R11 released
    12'b00_00_0100_1010, // R11 waiting
    12'b00_00_0001_1100, // R11 init done
    12'b00_00_0000_1100  // R11 normal
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act {cke,rdy,frz,dpd}=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] l, input logic [1:0] t,
                       input logic s, input logic r, input logic b, input logic i);
    @(negedge clk);
    lp_cmd = l; tmo = t; sel = s; req = r; busy = b; init = i;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] outs();
    return {cke, rdy, frz, dpd};
  endfunction

  task automatic wake(input logic [1:0] t);
    drive(2'b10, t, 1'b0, 1'b1, 1'b0, 1'b0);
    step(); check("R8 wake", outs(), 4'b1000);
    step(); check("R8 delay", outs(), 4'b1000);
    step(); check("R8 grant", outs(), 4'b1100);
  endtask

  task automatic window(input string tag, input logic [1:0] t, input int n);
    drive(2'b10, t, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    drive(2'b10, t, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (n) step();
    check(tag, outs(), 4'b1100);
    step();
    check(tag, outs(), 4'b0000);
    wake(t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lp_cmd = 2'b00; tmo = 2'b00; sel = 1'b0; req = 1'b0; busy = 1'b0; init = 1'b0;
    #3 check("R1 reset", outs(), 4'b1100);
    @(negedge clk); rst_ni = 1'b1;
    step(); check("R1 after reset", outs(), 4'b1100);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][11:10], VEC[k][9:8], VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4]);
      step();
      check($sformatf("vector %0d", k), outs(), VEC[k][3:0]);
    end

    window("R4 short window", 2'b01, 64);
    window("R5 long window", 2'b10, 128);

    // R6: access mid-window restarts the count
    drive(2'b10, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0); step();
    drive(2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0); repeat (40) step();
    check("R6 before access", outs(), 4'b1100);
    window("R6 restarted window", 2'b01, 64);

    // R7: busy holds off immediate entry until it drops
    drive(2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (5) step();
    check("R7 busy hold", outs(), 4'b1100);
    drive(2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0); step();
    check("R7 entry after busy", outs(), 4'b0000);

    // R1: asynchronous reset from power-down
    #2 rst_ni = 1'b0;
    #1 check("R1 reset in power-down", outs(), 4'b1100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule